// File: doc/BRIEF.md
# Lockable extended CRTC register bank

This block is an indexed register bank for a CRTC-style index/data port pair. The host first loads an 8-bit index. It then reads or writes the byte at that index through the data port. Indices below the lock-control register form a plain standard array that is always accessible. The lock-control register holds two independent keys, one for reads and one for writes, and three spare bits.

Every index above the lock-control register counts as extended. The keys guard all extended indices. When reads are locked, an extended read returns all ones. When writes are locked, an extended write is dropped. Five extended slots hold storage:

- an EGA switch readback byte
- a scratch byte
- interlace start
- interlace end
- a misc control byte

Extended indices past these five read as zero and hold nothing. A debug read input lets an inspector see extended contents without opening the read key.

Top module: `crtc_ext_bank`

## Requirements
- R1: `index_we` loads `wdata` into the index register. `index_o` shows the index unchanged in the cycle after the write and holds it until the next `index_we`. The index resets to 0x00.
- R2: Indices 0x00–0x28 are a standard byte array that is always readable and writable. `rdata` is registered: it shows the selected byte in the cycle after `data_re` and holds while `data_re` is low.
- R3: A data write to index 0x29 sets the read key only when bit 7 is 1 and bit 3 is 0, and clears it otherwise. The same write sets the write key only when bits 2:0 equal 3'b101, and clears it otherwise. It stores bits 6:4 as spare bits.
- R4: A read of index 0x29 returns the following, and is allowed whatever the keys:
  - bit 7 is the read key
  - bits 6:4 are the spare bits
  - bits 2 and 0 are both the write key
  - bits 3 and 1 are 0
- R5: A data read of any index 0x2A–0xFF while the read key is clear and `dbg_rd` is low returns 0xFF and changes no state.
- R6: A data write to any index 0x2A–0xFF while the write key is clear leaves every stored byte unchanged.
- R7: With the keys open, indices 0x2A (EGA switch), 0x2B (scratch), 0x2C (interlace start), 0x2D (interlace end) and 0x2E (misc control) are full 8-bit read/write bytes.
- R8: Indices 0x2F–0xFF read 0x00 when the read key is open or `dbg_rd` is high, and writes to them have no effect.
- R9: After reset both keys and the spare bits are 0, index 0x2A holds 0xF0, and indices 0x2B–0x2E hold 0x00.
- R10: A data read with `dbg_rd` high returns the stored extended value regardless of the read key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| index_we | input | 1 | Load the index register from `wdata` |
| data_we | input | 1 | Write `wdata` to the selected index |
| data_re | input | 1 | Read the selected index into `rdata` |
| dbg_rd | input | 1 | Debug read: bypass the read key |
| wdata | input | 8 | Write data for index and data port |
| index_o | output | 8 | Current index readback |
| rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with its default parameters. The lock index is 0x29, so 41 standard bytes sit below it. There are five used extended slots and the EGA reset value is 0xF0. With these values one 8-bit index reaches every region: the standard array, the lock register, the five stored slots and the 0xD1 unused extended indices, up to 0xFF where the index width ends.

Random traffic is biased around the 0x28–0x2F boundary and mixes in random key bytes. This drives every key combination against reads, writes and debug reads. Directed cases cover the bit-3 veto on the read key, near-miss write keys and the far end of the index range.

// File: rtl/crtc_bank_pkg.sv
package crtc_bank_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic       rd_open;
    logic       wr_open;
    logic [2:0] spare;
  } lock_state_t;
endpackage

// File: rtl/crtc_lock_ctrl.sv
module crtc_lock_ctrl
  import crtc_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  byte_t       wdata,
  output lock_state_t st,
  output byte_t       status
);
  lock_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (we) begin
      st_q.rd_open <= wdata[7] & ~wdata[3];
      st_q.wr_open <= (wdata[2:0] == 3'b101);
      st_q.spare   <= wdata[6:4];
    end
  end

  assign st     = st_q;
  assign status = {st_q.rd_open, st_q.spare, 1'b0, st_q.wr_open, 1'b0, st_q.wr_open};

  // R3: a write without the 3'b101 pattern always closes the write key
  a_r3_wr_key_closes: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[2:0] != 3'b101) |=> !status[0]);
  // R3: bit 3 set in a lock write vetoes the read key
  a_r3_rd_key_veto: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[3]) |=> !status[7]);
  // R9: after a reset cycle both keys are closed
  a_r9_reset_locked: assert property (@(posedge clk)
    $past(rst) |-> (status == 8'h00));
endmodule

// File: rtl/crtc_std_array.sv
module crtc_std_array
  import crtc_bank_pkg::*;
#(
  parameter int unsigned DEPTH = 41,
  localparam int unsigned AW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  byte_t         wdata,
  output byte_t         rdata
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/crtc_ext_file.sv
module crtc_ext_file
  import crtc_bank_pkg::*;
#(
  parameter int unsigned SLOTS    = 5,
  parameter byte_t       EGA_INIT = 8'hF0,
  localparam int unsigned SW      = $clog2(SLOTS)
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic                  hit,
  input  logic [SW-1:0]         slot,
  input  byte_t                 wdata,
  output byte_t                 rdata,
  output logic [SLOTS*BYTE_W-1:0] flat
);
  byte_t regs [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam byte_t INIT = (g == 0) ? EGA_INIT : 8'h00;
    always_ff @(posedge clk) begin
      if (rst)                                  regs[g] <= INIT;
      else if (we && hit && slot == SW'(g))     regs[g] <= wdata;
    end
    assign flat[g*BYTE_W +: BYTE_W] = regs[g];
  end

  assign rdata = hit ? regs[slot] : 8'h00;
endmodule

// File: rtl/crtc_ext_bank.sv
module crtc_ext_bank
  import crtc_bank_pkg::*;
#(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned LOCK_IDX = 41,
  parameter int unsigned EXT_USED = 5,
  parameter byte_t       EGA_INIT = 8'hF0
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             index_we,
  input  logic             data_we,
  input  logic             data_re,
  input  logic             dbg_rd,
  input  logic [7:0]       wdata,
  output logic [IDX_W-1:0] index_o,
  output logic [7:0]       rdata
);
  localparam int unsigned STD_DEPTH = LOCK_IDX;
  localparam int unsigned STD_AW    = $clog2(STD_DEPTH);
  localparam int unsigned EXT_SW    = $clog2(EXT_USED);
  localparam logic [IDX_W-1:0] LOCK_I = IDX_W'(LOCK_IDX);
  localparam logic [IDX_W-1:0] BASE_I = IDX_W'(LOCK_IDX + 1);
  localparam logic [IDX_W-1:0] USED_I = IDX_W'(EXT_USED);

  logic [IDX_W-1:0] idx_q;
  byte_t            rdata_q, rd_mux, std_rd, ext_rd, lock_stat;
  lock_state_t      lk;
  logic             is_std, is_lock, is_ext, ext_hit;
  logic [IDX_W-1:0] ext_off;
  logic [EXT_USED*BYTE_W-1:0] ext_flat;

  always_ff @(posedge clk) begin
    if (rst)           idx_q <= '0;
    else if (index_we) idx_q <= IDX_W'(wdata);
  end

  assign is_std  = idx_q < LOCK_I;
  assign is_lock = idx_q == LOCK_I;
  assign is_ext  = idx_q >= BASE_I;
  assign ext_off = idx_q - BASE_I;
  assign ext_hit = is_ext && (ext_off < USED_I);

  crtc_std_array #(.DEPTH(STD_DEPTH)) u_std (
    .clk  (clk),
    .we   (data_we && is_std),
    .addr (idx_q[STD_AW-1:0]),
    .wdata(wdata),
    .rdata(std_rd)
  );

  crtc_lock_ctrl u_lock (
    .clk   (clk),
    .rst   (rst),
    .we    (data_we && is_lock),
    .wdata (wdata),
    .st    (lk),
    .status(lock_stat)
  );

  crtc_ext_file #(.SLOTS(EXT_USED), .EGA_INIT(EGA_INIT)) u_ext (
    .clk  (clk),
    .rst  (rst),
    .we   (data_we && lk.wr_open),
    .hit  (ext_hit),
    .slot (ext_off[EXT_SW-1:0]),
    .wdata(wdata),
    .rdata(ext_rd),
    .flat (ext_flat)
  );

  always_comb begin
    if (is_std)                        rd_mux = std_rd;
    else if (is_lock)                  rd_mux = lock_stat;
    else if (lk.rd_open || dbg_rd)     rd_mux = ext_rd;
    else                               rd_mux = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (data_re) rdata_q <= rd_mux;
  end

  assign rdata   = rdata_q;
  assign index_o = idx_q;

  // R1: index holds without index_we
  a_r1_index_holds: assert property (@(posedge clk) disable iff (rst)
    !index_we |=> $stable(index_o));
  // R2: read data holds without data_re
  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !data_re |=> $stable(rdata));
  // R5: locked extended read yields all ones
  a_r5_locked_read_ones: assert property (@(posedge clk) disable iff (rst)
    (data_re && is_ext && !lk.rd_open && !dbg_rd) |=> (rdata == 8'hFF));
  // R6: locked extended write keeps every stored byte
  a_r6_locked_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (data_we && is_ext && !lk.wr_open) |=> $stable(ext_flat));
  // R8: unused extended index never alters stored bytes
  a_r8_unused_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (data_we && is_ext && !ext_hit) |=> $stable(ext_flat));
endmodule

// File: tb/tb_crtc_ext_bank.sv
module tb_crtc_ext_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic index_we = 0, data_we = 0, data_re = 0, dbg_rd = 0;
  logic [7:0] wdata = 0;
  logic [7:0] index_o, rdata;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  logic [7:0] std_m [41];
  logic [7:0] ext_m [5];
  logic rd_m, wr_m;
  logic [2:0] sp_m;
  logic [7:0] cur_idx;

  crtc_ext_bank dut (
    .clk(clk), .rst(rst), .index_we(index_we), .data_we(data_we),
    .data_re(data_re), .dbg_rd(dbg_rd), .wdata(wdata),
    .index_o(index_o), .rdata(rdata)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles exp < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] exp_read(input logic [7:0] i, input logic dbg);
    if (i < 8'h29) return std_m[i];
    if (i == 8'h29) return {rd_m, sp_m, 1'b0, wr_m, 1'b0, wr_m};
    if (!rd_m && !dbg) return 8'hFF;
    if (i <= 8'h2E) return ext_m[i - 8'h2A];
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [7:0] i, input logic dbg);
    if (i < 8'h29) return "R2";
    if (i == 8'h29) return "R4";
    if (!rd_m && !dbg) return "R5";
    if (!rd_m) return "R10";
    if (i <= 8'h2E) return "R7";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s idx=%h got %h exp %h", tag, cur_idx, got, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] i);
    index_we = 1; wdata = i;
    @(negedge clk);
    index_we = 0;
    cur_idx = i;
    check("R1", index_o, i);
  endtask

  task automatic wr(input logic [7:0] d);
    data_we = 1; wdata = d;
    @(negedge clk);
    data_we = 0;
    if (cur_idx < 8'h29) std_m[cur_idx] = d;
    else if (cur_idx == 8'h29) begin
      rd_m = d[7] & ~d[3];
      wr_m = (d[2:0] == 3'b101);
      sp_m = d[6:4];
    end else if (wr_m && cur_idx <= 8'h2E) ext_m[cur_idx - 8'h2A] = d;
  endtask

  task automatic rd(input logic dbg, input string tag);
    logic [7:0] e;
    e = exp_read(cur_idx, dbg);
    data_re = 1; dbg_rd = dbg;
    @(negedge clk);
    data_re = 0; dbg_rd = 0;
    check(tag, rdata, e);
  endtask

  task automatic rd_auto(input logic dbg);
    rd(dbg, tag_of(cur_idx, dbg));
  endtask

  initial begin
    void'($urandom(32'd1234));
    rd_m = 0; wr_m = 0; sp_m = 0;
    ext_m[0] = 8'hF0;
    for (int k = 1; k < 5; k++) ext_m[k] = 8'h00;
    cur_idx = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R9 / R1: reset state
    check("R1", index_o, 8'h00);
    check("R2", rdata, 8'h00);
    set_idx(8'h29); rd(0, "R9");
    set_idx(8'h2A); rd(0, "R5");
    rd(1, "R10");
    rd(1, "R9");
    for (int k = 8'h2B; k <= 8'h2E; k++) begin
      set_idx(8'(k)); rd(1, "R9");
    end

    // R2: fill the standard array
    for (int k = 0; k < 41; k++) begin
      set_idx(8'(k)); wr(8'(k * 37 + 5));
    end
    set_idx(8'h00); rd(0, "R2");
    set_idx(8'h28); rd(0, "R2");

    // R6: locked write discarded, then seen through debug read
    set_idx(8'h2B); wr(8'h5A); rd(1, "R6");

    // R3 / R4: key patterns
    set_idx(8'h29); wr(8'h85); rd(0, "R3");
    set_idx(8'h29); wr(8'hF5); rd(0, "R4");
    wr(8'h8D); rd(0, "R3");
    wr(8'h84); rd(0, "R3");
    wr(8'h06); rd(0, "R3");
    wr(8'h85);

    // R7: all stored slots writable when open
    for (int k = 8'h2A; k <= 8'h2E; k++) begin
      set_idx(8'(k)); wr(8'(k ^ 8'hC3)); rd(0, "R7");
    end

    // R8: unused extended indices
    set_idx(8'h2F); wr(8'h77); rd(0, "R8");
    set_idx(8'hFF); wr(8'h11); rd(0, "R8");
    set_idx(8'h29); wr(8'h00);
    set_idx(8'hFF); rd(0, "R5");
    rd(1, "R8");
    set_idx(8'h2C); rd(1, "R10");

    // random traffic around the boundary
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom % 8;
      if (op == 0) begin
        if ($urandom % 4 == 0) set_idx(8'($urandom));
        else set_idx(8'(8'h26 + $urandom % 12));
      end else if (op == 1) begin
        set_idx(8'h29);
        if ($urandom % 2) wr(8'($urandom) & 8'h77 | 8'h85);
        else wr(8'($urandom));
      end else if (op <= 4) begin
        wr(8'($urandom));
      end else begin
        rd_auto(logic'($urandom % 4 == 0));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule